// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block works out the effective memory address for a load or store instruction, together with the value that gets written back to the base register when the instruction asks for one. It takes a base register value, the program counter, an index register value and a 19-bit immediate field. It supports six addressing modes, and each mode reads the immediate with its own width, signedness and scale factor. The access size, the pair flag and the load/store flag decide which mode combinations are legal. An illegal combination raises a flag instead of producing an address.

The block has one register stage. A request presented with `inValid` high on one clock edge shows up on the outputs after that edge, qualified by `outValid`. All address arithmetic wraps modulo 2^AW. The memory access itself is done elsewhere.

Top module: `agu_top`

## Requirements
- R1: While `rstN` is low, every output is held at zero.
- R2: Results appear one clock after the request, and `outValid` equals the `inValid` of the previous cycle. When no request was presented, `effAddr`, `wbEn`, `wbVal` and `illegal` are all zero.
- R3: Mode 0 (unscaled) gives `effAddr` = base + sign-extended `imm[8:0]`, with no write-back.
- R4: Mode 1 without `isPair` (scaled) gives `effAddr` = base + zero-extended `imm[11:0]` × 2^`sizeLog2`, with no write-back.
- R5: Mode 1 with `isPair` gives `effAddr` = base + sign-extended `imm[6:0]` × 2^`sizeLog2`. It is legal only for `sizeLog2` 2 or 3.
- R6: Mode 2 (pre-index) gives `effAddr` = `wbVal` = base + sign-extended `imm[8:0]`, with `wbEn` high.
- R7: Mode 3 (post-index) gives `effAddr` = base and `wbVal` = base + sign-extended `imm[8:0]`, with `wbEn` high.
- R8: Mode 4 (literal) gives `effAddr` = pc + sign-extended `imm[18:0]` × 4. It is legal only for loads with `sizeLog2` 2 or 3 and without `isPair`.
- R9: Mode 5 (register) gives `effAddr` = base + ext(index) × (`extShift` ? 2^`sizeLog2` : 1). The values of `extSel` are: 0 zero-extends `idx[31:0]`, 1 uses the full index, 2 sign-extends `idx[31:0]`, and 3 uses the full index.
- R10: `illegal` is set for any of these cases: mode 6 or 7; `isPair` with any mode other than 1; a disallowed size; a literal store. An illegal request gives `effAddr` = 0, `wbVal` = 0 and `wbEn` = 0.
- R11: All sums wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| baseVal | input | AW | Base register value |
| pcVal | input | AW | Program counter |
| idxVal | input | AW | Index register value |
| imm | input | 19 | Immediate field |
| mode | input | 3 | Addressing mode, 0..5 |
| sizeLog2 | input | 2 | log2 of access bytes |
| extSel | input | 2 | Index extend option |
| extShift | input | 1 | Scale the index by the access size |
| isPair | input | 1 | Register-pair access |
| isLoad | input | 1 | 1 = load, 0 = store |
| outValid | output | 1 | Result valid |
| effAddr | output | AW | Effective address |
| wbEn | output | 1 | Base write-back enable |
| wbVal | output | AW | Base write-back value |
| illegal | output | 1 | Illegal combination |

## Verification
The bench builds the block with AW = 40. This width keeps the zero-extend and sign-extend index options distinct from the full-width options, because the index has bits above bit 31. It also keeps the largest scaled offsets, 4095 × 8, well inside the range. The bench sweeps every combination of mode, size, pair flag, load flag, extend option and shift flag. Each combination is tried with boundary immediates (most negative, most positive, all-ones) and with bases close to 2^40, so that carries wrap past the top of the address space.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam int IMM_W = 19;

  localparam logic [2:0] MODE_UNSC = 3'd0;
  localparam logic [2:0] MODE_SCAL = 3'd1;
  localparam logic [2:0] MODE_PRE  = 3'd2;
  localparam logic [2:0] MODE_POST = 3'd3;
  localparam logic [2:0] MODE_LIT  = 3'd4;
  localparam logic [2:0] MODE_REG  = 3'd5;

  typedef enum logic [2:0] {
    OFF_S9,
    OFF_U12,
    OFF_S7,
    OFF_S19,
    OFF_IDX
  } offSel_t;

  typedef struct packed {
    offSel_t offSel;
    logic    basePc;
    logic    addrFromSum;
    logic    wbEn;
    logic    illegal;
  } aguStrobes_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic [2:0]  mode,
  input  logic [1:0]  sizeLog2,
  input  logic        isPair,
  input  logic        isLoad,
  output aguStrobes_t strobes
);

  logic wideSize;
  assign wideSize = sizeLog2[1];

  always_comb begin
    strobes = '{offSel: OFF_S9, basePc: 1'b0, addrFromSum: 1'b1,
                wbEn: 1'b0, illegal: 1'b0};
    unique case (mode)
      MODE_UNSC: begin
        strobes.offSel  = OFF_S9;
        strobes.illegal = isPair;
      end
      MODE_SCAL: begin
        strobes.offSel  = isPair ? OFF_S7 : OFF_U12;
        strobes.illegal = isPair && !wideSize;
      end
      MODE_PRE: begin
        strobes.offSel  = OFF_S9;
        strobes.wbEn    = 1'b1;
        strobes.illegal = isPair;
      end
      MODE_POST: begin
        strobes.offSel      = OFF_S9;
        strobes.wbEn        = 1'b1;
        strobes.addrFromSum = 1'b0;
        strobes.illegal     = isPair;
      end
      MODE_LIT: begin
        strobes.offSel  = OFF_S19;
        strobes.basePc  = 1'b1;
        strobes.illegal = isPair || !isLoad || !wideSize;
      end
      MODE_REG: begin
        strobes.offSel  = OFF_IDX;
        strobes.illegal = isPair;
      end
      default: strobes.illegal = 1'b1;
    endcase
    if (strobes.illegal) strobes.wbEn = 1'b0;
  end

endmodule

// File: rtl/agu_dp.sv
module agu_dp
  import agu_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [AW-1:0]     baseVal,
  input  logic [AW-1:0]     pcVal,
  input  logic [AW-1:0]     idxVal,
  input  logic [IMM_W-1:0]  imm,
  input  logic [1:0]        sizeLog2,
  input  logic [1:0]        extSel,
  input  logic              extShift,
  input  aguStrobes_t       strobes,
  output logic              outValid,
  output logic [AW-1:0]     effAddr,
  output logic              wbEn,
  output logic [AW-1:0]     wbVal,
  output logic              illegal
);

  localparam int HI_W = AW - 32;

  logic [AW-1:0] offS9, offU12, offS7, offS19, idxExt, offIdx, offset, opA, sum;

  assign offS9  = {{(AW-9){imm[8]}}, imm[8:0]};
  assign offU12 = {{(AW-12){1'b0}}, imm[11:0]} << sizeLog2;
  assign offS7  = {{(AW-7){imm[6]}}, imm[6:0]} << sizeLog2;
  assign offS19 = {{(AW-IMM_W){imm[IMM_W-1]}}, imm} << 2;

  generate
    if (AW > 32) begin : g_wide
      always_comb begin
        unique case (extSel)
          2'd0:    idxExt = {{HI_W{1'b0}}, idxVal[31:0]};
          2'd2:    idxExt = {{HI_W{idxVal[31]}}, idxVal[31:0]};
          default: idxExt = idxVal;
        endcase
      end
    end else begin : g_narrow
      logic [1:0] unusedSel;
      assign unusedSel = extSel;
      assign idxExt    = idxVal;
    end
  endgenerate

  assign offIdx = extShift ? (idxExt << sizeLog2) : idxExt;

  always_comb begin
    unique case (strobes.offSel)
      OFF_S9:  offset = offS9;
      OFF_U12: offset = offU12;
      OFF_S7:  offset = offS7;
      OFF_S19: offset = offS19;
      default: offset = offIdx;
    endcase
  end

  assign opA = strobes.basePc ? pcVal : baseVal;
  assign sum = opA + offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      effAddr  <= '0;
      wbEn     <= 1'b0;
      wbVal    <= '0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      illegal  <= inValid && strobes.illegal;
      wbEn     <= inValid && strobes.wbEn;
      wbVal    <= (inValid && strobes.wbEn) ? sum : '0;
      if (!inValid || strobes.illegal) effAddr <= '0;
      else if (strobes.addrFromSum)   effAddr <= sum;
      else                            effAddr <= baseVal;
    end
  end

endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [AW-1:0]     baseVal,
  input  logic [AW-1:0]     pcVal,
  input  logic [AW-1:0]     idxVal,
  input  logic [IMM_W-1:0]  imm,
  input  logic [2:0]        mode,
  input  logic [1:0]        sizeLog2,
  input  logic [1:0]        extSel,
  input  logic              extShift,
  input  logic              isPair,
  input  logic              isLoad,
  output logic              outValid,
  output logic [AW-1:0]     effAddr,
  output logic              wbEn,
  output logic [AW-1:0]     wbVal,
  output logic              illegal
);

  aguStrobes_t strobes;

  agu_ctrl u_ctrl (
    .mode     (mode),
    .sizeLog2 (sizeLog2),
    .isPair   (isPair),
    .isLoad   (isLoad),
    .strobes  (strobes)
  );

  agu_dp #(.AW(AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .baseVal  (baseVal),
    .pcVal    (pcVal),
    .idxVal   (idxVal),
    .imm      (imm),
    .sizeLog2 (sizeLog2),
    .extSel   (extSel),
    .extShift (extShift),
    .strobes  (strobes),
    .outValid (outValid),
    .effAddr  (effAddr),
    .wbEn     (wbEn),
    .wbVal    (wbVal),
    .illegal  (illegal)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [AW-1:0] baseVal,
  input logic [2:0]    mode,
  input logic          isPair,
  input logic          isLoad,
  input logic          outValid,
  input logic [AW-1:0] effAddr,
  input logic          wbEn,
  input logic [AW-1:0] wbVal,
  input logic          illegal
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!wbEn && !illegal && effAddr == '0));

  a_r7_post_uses_base: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 3'd3 && !isPair) |=> (wbEn && effAddr == $past(baseVal)));

  a_r6_pre_addr_is_wb: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 3'd2 && !isPair) |=> (wbEn && effAddr == wbVal));

  a_r8_store_literal_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 3'd4 && !isLoad) |=> illegal);

  a_r10_pair_mode_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isPair && mode != 3'd1) |=> illegal);

  a_r10_illegal_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!wbEn && effAddr == '0 && wbVal == '0));

endmodule

bind agu_top agu_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .baseVal  (baseVal),
  .mode     (mode),
  .isPair   (isPair),
  .isLoad   (isLoad),
  .outValid (outValid),
  .effAddr  (effAddr),
  .wbEn     (wbEn),
  .wbVal    (wbVal),
  .illegal  (illegal)
);

// File: tb/agu_top_test.sv
`timescale 1ns/1ps
module agu_top_test;

  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [AW-1:0] baseVal = '0, pcVal = '0, idxVal = '0;
  logic [18:0]   imm = '0;
  logic [2:0]    mode = '0;
  logic [1:0]    sizeLog2 = '0, extSel = '0;
  logic          extShift = 1'b0, isPair = 1'b0, isLoad = 1'b0;
  logic          outValid, wbEn, illegal;
  logic [AW-1:0] effAddr, wbVal;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  agu_top #(.AW(AW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .baseVal(baseVal),
    .pcVal(pcVal), .idxVal(idxVal), .imm(imm), .mode(mode),
    .sizeLog2(sizeLog2), .extSel(extSel), .extShift(extShift),
    .isPair(isPair), .isLoad(isLoad), .outValid(outValid),
    .effAddr(effAddr), .wbEn(wbEn), .wbVal(wbVal), .illegal(illegal)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  task automatic check(string tag, bit [AW-1:0] eA, bit eWe, bit [AW-1:0] eW,
                       bit eIl, bit eV);
    nTests++;
    if (effAddr !== eA || wbEn !== eWe || wbVal !== eW || illegal !== eIl ||
        outValid !== eV) begin
      nFail++;
      $display("FAIL %s: got addr=%h we=%b wb=%h il=%b v=%b exp addr=%h we=%b wb=%h il=%b v=%b",
               tag, effAddr, wbEn, wbVal, illegal, outValid, eA, eWe, eW, eIl, eV);
    end
  endtask

  function automatic longint sx(longint v, int w);
    return (v >= (64'sd1 <<< (w-1))) ? v - (64'sd1 <<< w) : v;
  endfunction

  task automatic apply_and_check();
    longint off, opA;
    bit il, we;
    bit [AW-1:0] eA, eW;
    string tag;
    int md = mode;
    int sz = sizeLog2;
    int scale = 1 << sz;
    il = (md > 5) || (isPair && md != 1) || (md == 1 && isPair && sz < 2) ||
         (md == 4 && (!isLoad || sz < 2));
    opA = (md == 4) ? longint'(pcVal) : longint'(baseVal);
    case (md)
      0, 2, 3: off = sx(imm[8:0], 9);
      1: off = isPair ? sx(imm[6:0], 7) * scale : longint'(imm[11:0]) * scale;
      4: off = sx(imm, 19) * 4;
      default: begin
        case (extSel)
          2'd0: off = longint'(idxVal[31:0]);
          2'd2: off = sx(idxVal[31:0], 32);
          default: off = longint'(idxVal);
        endcase
        if (extShift) off = off * scale;
      end
    endcase
    we = !il && (md == 2 || md == 3);
    eW = we ? AW'(opA + off) : '0;
    eA = il ? '0 : (md == 3 ? baseVal : AW'(opA + off));
    case (md)
      0: tag = "R3/R11"; 1: tag = isPair ? "R5/R11" : "R4/R11";
      2: tag = "R6/R11"; 3: tag = "R7/R11"; 4: tag = "R8/R11";
      5: tag = "R9/R11"; default: tag = "R10";
    endcase
    if (il) tag = "R10";
    inValid = 1'b1;
    @(negedge clk);
    check(tag, eA, we, eW, il, 1'b1);
  endtask

  initial begin
    bit [18:0] imms [4];
    bit [AW-1:0] bases [2];
    imms = '{19'h40000, 19'h3FFFF, 19'h7FFFF, 19'h000FF};
    bases = '{40'hFF_FFFF_FFF0, 40'h00_0000_0100};
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0, '0, 1'b0, 1'b0);
    rstN = 1'b1;
    baseVal = 40'h12_3456_7890; mode = 3'd2;
    @(negedge clk);
    check("R2 idle", '0, 1'b0, '0, 1'b0, 1'b0);
    for (int md = 0; md < 8; md++)
      for (int sz = 0; sz < 4; sz++)
        for (int pl = 0; pl < 4; pl++)
          for (int ex = 0; ex < 8; ex++)
            for (int k = 0; k < 4; k++) begin
              mode = 3'(md); sizeLog2 = 2'(sz);
              isPair = pl[0]; isLoad = pl[1];
              extSel = 2'(ex); extShift = ex[2];
              imm = imms[k];
              baseVal = (k[0]) ? bases[0] : bases[1] ^ AW'({$urandom, $urandom});
              pcVal = (k[1]) ? bases[0] : AW'({$urandom, $urandom});
              idxVal = (k == 2) ? 40'hFF_8000_0004 : AW'({$urandom, $urandom});
              apply_and_check();
            end
    inValid = 1'b0;
    @(negedge clk);
    check("R2 drop", '0, 1'b0, '0, 1'b0, 1'b0);
    rstN = 1'b0; inValid = 1'b1;
    @(negedge clk);
    check("R1 reset", '0, 1'b0, '0, 1'b0, 1'b0);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

endmodule